// File: doc/BRIEF.md
# Integer ALU with Flag Generation

This block is the integer arithmetic and logic stage of a 32-bit datapath. Each cycle it takes a destination operand, a source operand, an operation code, a size select and the current carry flag. It returns the result at once, together with a result write-enable. It also returns the sign, zero, overflow and carry values, each with its own update enable. The four flags sit in a small register inside the block. On a valid operation, only the flags whose enable is set are loaded at the clock edge.

Two operand sizes are supported: byte and doubleword. In byte mode every flag is taken from the low eight bits. The upper bits of the result carry the destination's upper bits through unchanged, so the caller can write the result back into a full-width register. Each operation has its own flag policy. Increment keeps the carry. The logical operations clear overflow and carry. The test operation updates flags but writes no result. Complement touches no flag at all.

Top module: `iflag_alu`

## Requirements
- R1: A synchronous reset clears the flag register `flags_q` to 0. Its bit order is 3 = sign, 2 = zero, 1 = overflow, 0 = carry. `flag_upd` uses the same order.
- R2: Opcode 0 (add) drives `res` = opa + opb and updates all four flags. Carry is the unsigned carry-out. Overflow is set when the signed sum does not fit the selected width.
- R3: Opcode 1 (subtract) drives `res` = opa − opb. Opcode 2 (subtract with borrow) drives `res` = opa − opb − `cf_in`. Both update all four flags. Carry is the borrow out, and overflow is signed overflow of the difference.
- R4: Opcode 3 (negate) drives `res` = 0 − opa and updates all four flags. Carry is 1 exactly when the operand is nonzero. Overflow is 1 only for the most negative value.
- R5: Opcode 4 (increment) drives `res` = opa + 1. It updates sign, zero and overflow (`flag_upd` = 4'b1110), and the carry flag keeps its previous value.
- R6: Opcode 5 (OR) and opcode 6 (XOR) write the bitwise result, set sign and zero from it, and force overflow and carry to 0.
- R7: Opcode 7 (test) ANDs the operands only to form sign and zero. It forces overflow and carry to 0 and keeps `res_we` low.
- R8: Opcode 8 (complement) drives `res` = ~opa with `res_we` high. `flag_upd` is 0 and `flags_q` does not change.
- R9: With `size_dword` = 0, sign is bit 7 of the result and zero means bits 7:0 are all 0. Carry and overflow come from an 8-bit operation, and `res[31:8]` equals `opa[31:8]`. With `size_dword` = 1, all 32 bits are used.
- R10: With `op_valid` low, or with a reserved opcode (9 to 15), `res_we` and `flag_upd` are 0 and `flags_q` holds.
- R11: `flags_q` changes only at a clock edge. At that edge it loads the flags computed in that cycle, for exactly the bits set in `flag_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select (0 to 8 used) |
| size_dword | input | 1 | 1 = 32-bit operands, 0 = byte operands |
| opa | input | 32 | Destination operand |
| opb | input | 32 | Source operand |
| cf_in | input | 1 | Incoming carry flag for subtract with borrow |
| res | output | 32 | Operation result |
| res_we | output | 1 | Result write-enable |
| flag_upd | output | 4 | Per-flag update enables (S, Z, O, C) |
| flags_q | output | 4 | Registered flags (S, Z, O, C) |

## Verification
A partial flag update and a full result write land in the same cycle whenever increment runs. Its result, sign, zero and overflow are all fresh, while its carry must survive from the operation before. The bench first sets the carry with an add that wraps to zero. It then increments a byte from 0x7F, and separately a doubleword from all ones. After the edge it compares the result port with the expected sum, and compares `flags_q` with a shadow copy in which only sign, zero and overflow were replaced. The reverse case is test: flags update but the result write stays off. It is judged by sampling `res_we` in the operation's own cycle and the flags one edge later.

// File: rtl/iflag_alu_pkg.sv
package iflag_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_SBB  = 4'd2,
      OP_NEG  = 4'd3,
      OP_INC  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_TEST = 4'd7,
      OP_NOT  = 4'd8
   } alu_op_e;

   typedef enum logic [1:0] {
      Y_OPB  = 2'd0,
      Y_OPA  = 2'd1,
      Y_ZERO = 2'd2
   } y_src_e;

   typedef enum logic [1:0] {
      LF_OR  = 2'd0,
      LF_XOR = 2'd1,
      LF_AND = 2'd2,
      LF_NOT = 2'd3
   } logic_fn_e;

   // packed order gives bit 3 = sign ... bit 0 = carry
   typedef struct packed {
      logic s;
      logic z;
      logic o;
      logic c;
   } alu_flags_t;

   localparam int NUM_FLAGS = 4;

   typedef struct packed {
      logic                 x_zero;
      y_src_e               y_src;
      logic                 y_inv;
      logic                 cin;
      logic                 borrow;
      logic                 use_logic;
      logic_fn_e            lfn;
      logic                 res_we;
      logic [NUM_FLAGS-1:0] upd;
   } alu_ctl_t;

endpackage

// File: rtl/iflag_alu_ctl.sv
module iflag_alu_ctl
   import iflag_alu_pkg::*;
(
   input  logic       op_valid,
   input  logic [3:0] op_code,
   input  logic       cf_in,
   output alu_ctl_t   ctl_o
);

   localparam logic [NUM_FLAGS-1:0] UPD_ALL  = '1;
   localparam logic [NUM_FLAGS-1:0] UPD_NO_C = 4'b1110;

   alu_ctl_t dec;

   always_comb begin
      dec           = '0;
      dec.y_src     = Y_OPB;
      dec.lfn       = LF_OR;
      unique case (op_code)
         OP_ADD: begin
            dec.res_we = 1'b1;
            dec.upd    = UPD_ALL;
         end
         OP_SUB: begin
            dec.y_inv  = 1'b1;
            dec.cin    = 1'b1;
            dec.borrow = 1'b1;
            dec.res_we = 1'b1;
            dec.upd    = UPD_ALL;
         end
         OP_SBB: begin
            dec.y_inv  = 1'b1;
            dec.cin    = ~cf_in;
            dec.borrow = 1'b1;
            dec.res_we = 1'b1;
            dec.upd    = UPD_ALL;
         end
         OP_NEG: begin
            dec.x_zero = 1'b1;
            dec.y_src  = Y_OPA;
            dec.y_inv  = 1'b1;
            dec.cin    = 1'b1;
            dec.borrow = 1'b1;
            dec.res_we = 1'b1;
            dec.upd    = UPD_ALL;
         end
         OP_INC: begin
            dec.y_src  = Y_ZERO;
            dec.cin    = 1'b1;
            dec.res_we = 1'b1;
            dec.upd    = UPD_NO_C;
         end
         OP_OR: begin
            dec.use_logic = 1'b1;
            dec.lfn       = LF_OR;
            dec.res_we    = 1'b1;
            dec.upd       = UPD_ALL;
         end
         OP_XOR: begin
            dec.use_logic = 1'b1;
            dec.lfn       = LF_XOR;
            dec.res_we    = 1'b1;
            dec.upd       = UPD_ALL;
         end
         OP_TEST: begin
            dec.use_logic = 1'b1;
            dec.lfn       = LF_AND;
            dec.upd       = UPD_ALL;
         end
         OP_NOT: begin
            dec.use_logic = 1'b1;
            dec.lfn       = LF_NOT;
            dec.res_we    = 1'b1;
         end
         default: begin
            dec.res_we = 1'b0;
            dec.upd    = '0;
         end
      endcase
   end

   always_comb begin
      ctl_o = dec;
      if (!op_valid) begin
         ctl_o.res_we = 1'b0;
         ctl_o.upd    = '0;
      end
   end

endmodule

// File: rtl/iflag_alu_addsub.sv
module iflag_alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         inv_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);

   if (W < 2) begin : g_bad_w
      $error("iflag_alu_addsub: W must be at least 2");
   end

   logic [W-1:0] y_eff;
   logic [W:0]   full;

   always_comb begin
      y_eff  = inv_i ? ~y_i : y_i;
      full   = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, cin_i};
      sum_o  = full[W-1:0];
      cout_o = full[W];
      // like-signed inputs giving an opposite-signed sum
      ovf_o  = (x_i[W-1] == y_eff[W-1]) && (full[W-1] != x_i[W-1]);
   end

endmodule

// File: rtl/iflag_alu_logic.sv
module iflag_alu_logic
   import iflag_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic_fn_e    fn_i,
   output logic [W-1:0] out_o
);

   always_comb begin
      unique case (fn_i)
         LF_OR:   out_o = a_i | b_i;
         LF_XOR:  out_o = a_i ^ b_i;
         LF_AND:  out_o = a_i & b_i;
         LF_NOT:  out_o = ~a_i;
         default: out_o = '0;
      endcase
   end

endmodule

// File: rtl/iflag_alu_flagreg.sv
module iflag_alu_flagreg
   import iflag_alu_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_FLAGS-1:0] upd_i,
   input  alu_flags_t           nxt_i,
   output logic [NUM_FLAGS-1:0] q_o
);

   logic [NUM_FLAGS-1:0] nxt_v;
   assign nxt_v = nxt_i;

   for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)           q_o[b] <= 1'b0;
         else if (upd_i[b]) q_o[b] <= nxt_v[b];
      end
   end

endmodule

// File: rtl/iflag_alu.sv
module iflag_alu
   import iflag_alu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BYTE_W   = 8,
   parameter bit BYTE_OPS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              size_dword,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              cf_in,
   output logic [DATA_W-1:0] res,
   output logic              res_we,
   output logic [3:0]        flag_upd,
   output logic [3:0]        flags_q
);

   localparam int NUM_LANES = BYTE_OPS ? 2 : 1;
   localparam int HI_W      = DATA_W - BYTE_W;

   if (BYTE_W < 2 || DATA_W <= BYTE_W) begin : g_bad_size
      $error("iflag_alu: need 2 <= BYTE_W < DATA_W");
   end
   if (DATA_W % BYTE_W != 0) begin : g_bad_ratio
      $error("iflag_alu: DATA_W must be a multiple of BYTE_W");
   end

   alu_ctl_t ctl;

   iflag_alu_ctl u_ctl (
      .op_valid (op_valid),
      .op_code  (op_code),
      .cf_in    (cf_in),
      .ctl_o    (ctl)
   );

   // lane 0 is full width, lane 1 (if present) is byte width
   logic [DATA_W-1:0] lane_sum  [NUM_LANES];
   logic              lane_cout [NUM_LANES];
   logic              lane_ovf  [NUM_LANES];

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? DATA_W : BYTE_W;
      logic [LW-1:0] x_l, y_l, s_l;
      logic          co_l, ov_l;

      always_comb begin
         x_l = ctl.x_zero ? '0 : opa[LW-1:0];
         unique case (ctl.y_src)
            Y_OPA:   y_l = opa[LW-1:0];
            Y_ZERO:  y_l = '0;
            default: y_l = opb[LW-1:0];
         endcase
      end

      iflag_alu_addsub #(.W(LW)) u_add (
         .x_i    (x_l),
         .y_i    (y_l),
         .inv_i  (ctl.y_inv),
         .cin_i  (ctl.cin),
         .sum_o  (s_l),
         .cout_o (co_l),
         .ovf_o  (ov_l)
      );

      assign lane_sum[g]  = DATA_W'(s_l);
      assign lane_cout[g] = co_l;
      assign lane_ovf[g]  = ov_l;
   end

   logic byte_sel;
   if (BYTE_OPS) begin : g_size_sel
      assign byte_sel = ~size_dword;
   end else begin : g_size_fixed
      logic unused_size;
      assign unused_size = size_dword;
      assign byte_sel    = 1'b0;
   end

   logic [DATA_W-1:0] logic_out;

   iflag_alu_logic #(.W(DATA_W)) u_logic (
      .a_i   (opa),
      .b_i   (opb),
      .fn_i  (ctl.lfn),
      .out_o (logic_out)
   );

   logic [DATA_W-1:0] arith_sel, raw_res, res_full;
   logic              cout_sel, ovf_sel;
   alu_flags_t        nxt_flags;

   always_comb begin
      arith_sel = byte_sel ? lane_sum[NUM_LANES-1]  : lane_sum[0];
      cout_sel  = byte_sel ? lane_cout[NUM_LANES-1] : lane_cout[0];
      ovf_sel   = byte_sel ? lane_ovf[NUM_LANES-1]  : lane_ovf[0];
      raw_res   = ctl.use_logic ? logic_out : arith_sel;
      // byte operations keep the destination's upper bits
      res_full  = byte_sel ? {opa[DATA_W-1 -: HI_W], raw_res[BYTE_W-1:0]} : raw_res;
   end

   always_comb begin
      nxt_flags.s = byte_sel ? res_full[BYTE_W-1] : res_full[DATA_W-1];
      nxt_flags.z = byte_sel ? ~|res_full[BYTE_W-1:0] : ~|res_full;
      nxt_flags.o = ctl.use_logic ? 1'b0 : ovf_sel;
      nxt_flags.c = ctl.use_logic ? 1'b0 : (ctl.borrow ? ~cout_sel : cout_sel);
   end

   iflag_alu_flagreg u_flags (
      .clk   (clk),
      .rst   (rst),
      .upd_i (ctl.upd),
      .nxt_i (nxt_flags),
      .q_o   (flags_q)
   );

   assign res      = res_full;
   assign res_we   = ctl.res_we;
   assign flag_upd = ctl.upd;

endmodule

// File: rtl/iflag_alu_chk.sv
module iflag_alu_chk
   import iflag_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              op_valid,
   input logic [3:0]        op_code,
   input logic              size_dword,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [DATA_W-1:0] res,
   input logic              res_we,
   input logic [3:0]        flag_upd,
   input logic [3:0]        flags_q
);

   logic is_logic_op;
   assign is_logic_op = op_valid && (op_code == OP_OR || op_code == OP_XOR || op_code == OP_TEST);

   AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == OP_TEST) |-> !res_we); // R7

   AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == OP_NOT) |=> $stable(flags_q)); // R8

   AST_INC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == OP_INC) |=> $stable(flags_q[0])); // R5

   AST_LOGIC_CLEARS_OC: assert property (@(posedge clk) disable iff (rst)
      is_logic_op |=> (flags_q[1:0] == 2'b00)); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !op_valid |-> (!res_we && flag_upd == 4'b0000)); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(flags_q)); // R10

   AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
      (res_we && !size_dword) |-> (res[DATA_W-1:BYTE_W] == opa[DATA_W-1:BYTE_W])); // R9

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      (op_valid && flag_upd[2]) |=>
      (flags_q[2] == ($past(size_dword) ? ($past(res) == '0) : ($past(res[BYTE_W-1:0]) == '0)))); // R11

   AST_ADD_OVF: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_code == OP_ADD && size_dword) |=>
      (flags_q[1] == (($past(opa[DATA_W-1]) == $past(opb[DATA_W-1])) &&
                      ($past(res[DATA_W-1]) != $past(opa[DATA_W-1]))))); // R2

endmodule

bind iflag_alu iflag_alu_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .op_valid   (op_valid),
   .op_code    (op_code),
   .size_dword (size_dword),
   .opa        (opa),
   .opb        (opb),
   .res        (res),
   .res_we     (res_we),
   .flag_upd   (flag_upd),
   .flags_q    (flags_q)
);

// File: tb/iflag_alu_tb_top.sv
module iflag_alu_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = 4'd0;
   logic        size_dword = 1'b1;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        cf_in = 1'b0;
   logic [31:0] res;
   logic        res_we;
   logic [3:0]  flag_upd;
   logic [3:0]  flags_q;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 0;
   logic [3:0] mdl_flags = 4'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iflag_alu dut_i (
      .clk        (clk),
      .rst        (rst),
      .op_valid   (op_valid),
      .op_code    (op_code),
      .size_dword (size_dword),
      .opa        (opa),
      .opb        (opb),
      .cf_in      (cf_in),
      .res        (res),
      .res_we     (res_we),
      .flag_upd   (flag_upd),
      .flags_q    (flags_q)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // independent reference built from the requirement text
   task automatic ref_model(input logic [3:0] op, input bit dw, input logic [31:0] a, input logic [31:0] b,
                            input bit cin, input bit vld, output logic [31:0] r_full,
                            output bit we, output logic [3:0] upd, output logic [3:0] nf);
      longint mask, ua, ub, sa, sb, smax, smin, r, s;
      bit c, o;
      int w;
      w    = dw ? 32 : 8;
      mask = dw ? 64'hFFFF_FFFF : 64'hFF;
      ua   = longint'(a) & mask;
      ub   = longint'(b) & mask;
      smax = mask >> 1;
      smin = -(smax + 1);
      sa   = (ua > smax) ? ua - (mask + 1) : ua;
      sb   = (ub > smax) ? ub - (mask + 1) : ub;
      c = 0; o = 0; r = 0; s = 0; we = 0; upd = 4'h0;
      case (op)
         4'd0: begin r = ua + ub; c = (r > mask); s = sa + sb; o = (s > smax) || (s < smin); we = 1; upd = 4'hF; end
         4'd1: begin r = ua - ub; c = (ua < ub); s = sa - sb; o = (s > smax) || (s < smin); we = 1; upd = 4'hF; end
         4'd2: begin r = ua - ub - longint'(cin); c = (ua < ub + longint'(cin)); s = sa - sb - longint'(cin);
                     o = (s > smax) || (s < smin); we = 1; upd = 4'hF; end
         4'd3: begin r = -ua; c = (ua != 0); s = -sa; o = (s > smax); we = 1; upd = 4'hF; end
         4'd4: begin r = ua + 1; s = sa + 1; o = (s > smax); we = 1; upd = 4'b1110; end
         4'd5: begin r = ua | ub; we = 1; upd = 4'hF; end
         4'd6: begin r = ua ^ ub; we = 1; upd = 4'hF; end
         4'd7: begin r = ua & ub; we = 0; upd = 4'hF; end
         4'd8: begin r = ~ua; we = 1; upd = 4'h0; end
         default: begin r = 0; we = 0; upd = 4'h0; end
      endcase
      r      = r & mask;
      r_full = (a & ~32'(mask)) | 32'(r);
      nf     = {r[w-1], (r == 0), o, c};
      if (!vld) begin
         we  = 0;
         upd = 4'h0;
      end
   endtask

   task automatic run_op(input string req, input bit vld, input logic [3:0] op, input bit dw,
                         input logic [31:0] a, input logic [31:0] b, input bit cin);
      logic [31:0] er;
      bit          ewe;
      logic [3:0]  eupd, enf;
      ref_model(op, dw, a, b, cin, vld, er, ewe, eupd, enf);
      @(negedge clk);
      op_valid = vld; op_code = op; size_dword = dw; opa = a; opb = b; cf_in = cin;
      #1;
      chk(req, "res_we", 64'(res_we), 64'(ewe));
      chk(req, "flag_upd", 64'(flag_upd), 64'(eupd));
      if (ewe) chk(req, "res", 64'(res), 64'(er));
      mdl_flags = (mdl_flags & ~eupd) | (enf & eupd);
      @(negedge clk);
      op_valid = 1'b0;
      chk(req, "flags_q", 64'(flags_q), 64'(mdl_flags));
   endtask

   task automatic t_reset_start();
      @(negedge clk);
      chk("R1", "flags after reset", 64'(flags_q), 64'h0);
      rst = 1'b0;
   endtask

   task automatic t_add();
      run_op("R2", 1, 4'd0, 1, 32'hFFFF_FFFF, 32'h0000_0001, 0);
      chk("R2", "carry and zero set", 64'(flags_q), 64'b0101);
      run_op("R2", 1, 4'd0, 1, 32'h7FFF_FFFF, 32'h0000_0001, 0);
      chk("R2", "sign and overflow set", 64'(flags_q), 64'b1010);
      run_op("R2", 1, 4'd0, 1, 32'h1234_5678, 32'h0101_0101, 0);
   endtask

   task automatic t_sub();
      run_op("R3", 1, 4'd1, 1, 32'd5, 32'd7, 0);
      chk("R3", "borrow and sign", 64'(flags_q), 64'b1001);
      run_op("R3", 1, 4'd1, 1, 32'h8000_0000, 32'd1, 0);
      run_op("R3", 1, 4'd2, 1, 32'h8000_0000, 32'd0, 1);
      chk("R3", "sbb signed overflow", 64'(flags_q), 64'b0010);
      run_op("R3", 1, 4'd2, 0, 32'hAB00_0005, 32'h0000_0005, 1);
      chk("R3", "sbb byte borrow", 64'(flags_q), 64'b1001);
      run_op("R3", 1, 4'd2, 1, 32'd9, 32'd9, 0);
   endtask

   task automatic t_neg();
      run_op("R4", 1, 4'd3, 1, 32'd0, 32'd0, 0);
      chk("R4", "neg zero clears carry", 64'(flags_q), 64'b0100);
      run_op("R4", 0 == 1 ? 0 : 1, 4'd3, 0, 32'h0000_0080, 32'd0, 0);
      chk("R4", "neg most negative byte", 64'(flags_q), 64'b1011);
      run_op("R4", 1, 4'd3, 1, 32'd5, 32'd0, 0);
   endtask

   task automatic t_inc();
      run_op("R5", 1, 4'd0, 1, 32'hFFFF_FFFF, 32'd1, 0);
      run_op("R5", 1, 4'd4, 0, 32'h5500_007F, 32'd0, 0);
      chk("R5", "inc keeps carry at 1", 64'(flags_q[0]), 64'd1);
      chk("R5", "inc byte overflow", 64'(flags_q[3:1]), 64'b101);
      run_op("R5", 1, 4'd0, 1, 32'd1, 32'd1, 0);
      run_op("R5", 1, 4'd4, 1, 32'hFFFF_FFFF, 32'd0, 0);
      chk("R5", "inc wrap keeps carry at 0", 64'(flags_q), 64'b0100);
   endtask

   task automatic t_logic();
      run_op("R6", 1, 4'd0, 1, 32'h8000_0000, 32'h8000_0000, 0);
      run_op("R6", 1, 4'd5, 1, 32'h8000_0000, 32'h0000_0001, 0);
      chk("R6", "or clears O and C", 64'(flags_q), 64'b1000);
      run_op("R6", 1, 4'd6, 0, 32'hCDEF_005A, 32'h0000_005A, 0);
      chk("R6", "xor byte zero", 64'(flags_q), 64'b0100);
   endtask

   task automatic t_test();
      run_op("R7", 1, 4'd0, 1, 32'hFFFF_FFFF, 32'd1, 0);
      run_op("R7", 1, 4'd7, 1, 32'hF0F0_F0F0, 32'h8000_0001, 0);
      chk("R7", "test flags", 64'(flags_q), 64'b1000);
      run_op("R7", 1, 4'd7, 0, 32'hFFFF_FF0F, 32'hFFFF_FFF0, 0);
   endtask

   task automatic t_not();
      run_op("R8", 1, 4'd1, 1, 32'd1, 32'd2, 0);
      run_op("R8", 1, 4'd8, 1, 32'h0F0F_1234, 32'd0, 0);
      chk("R8", "not flags unchanged", 64'(flags_q), 64'b1001);
      run_op("R8", 1, 4'd8, 0, 32'h1234_00F0, 32'd0, 0);
   endtask

   task automatic t_byte();
      run_op("R9", 1, 4'd0, 0, 32'hDEAD_BE80, 32'h0000_0080, 0);
      chk("R9", "byte add zero/carry/ovf", 64'(flags_q), 64'b0111);
      run_op("R9", 1, 4'd0, 1, 32'h0000_0080, 32'h0000_0080, 0);
      chk("R9", "same add dword no flags", 64'(flags_q), 64'b0000);
   endtask

   task automatic t_idle();
      run_op("R10", 1, 4'd0, 1, 32'hFFFF_FFFF, 32'd1, 0);
      run_op("R10", 0, 4'd1, 1, 32'd1, 32'd2, 0);
      chk("R10", "idle keeps flags", 64'(flags_q), 64'b0101);
      run_op("R10", 1, 4'd12, 1, 32'd1, 32'd2, 0);
      run_op("R10", 1, 4'd15, 0, 32'd0, 32'd0, 0);
   endtask

   task automatic t_edge_only();
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd1; size_dword = 1'b1; opa = 32'd0; opb = 32'd1; cf_in = 1'b0;
      #1;
      chk("R11", "flags before edge", 64'(flags_q), 64'(mdl_flags));
      @(negedge clk);
      op_valid = 1'b0;
      mdl_flags = 4'b1001;
      chk("R11", "flags after edge", 64'(flags_q), 64'(mdl_flags));
   endtask

   task automatic t_reset_again();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1", "flags cleared by reset", 64'(flags_q), 64'h0);
      rst = 1'b0;
      mdl_flags = 4'h0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_start();
      t_add();
      t_sub();
      t_neg();
      t_inc();
      t_logic();
      t_test();
      t_not();
      t_byte();
      t_idle();
      t_edge_only();
      t_reset_again();
      repeat (2) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R11 watchdog expired: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule